// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host-side master for a three-wire serial converter that needs a conversion-start strobe, a serial clock and one serial data line. It derives the serial clock from the system clock through a run-time divider, issues the start strobe, shifts in a status bit and a 12-bit sample, and presents them as one right-justified parallel word with a single-cycle valid strobe.

Commands arrive over a valid/ready handshake and are taken only while no frame or power sequence is in flight. A command picks one conversion, free-running conversion, a light or deep power-down request (start pulses with the serial clock held low), or a wake pulse on the serial clock. After a deep power-down the converter's reference needs time to settle, so the controller repeats a requested conversion until the status bit in front of the data reads high.

Top module: `sadc_host_ctrl`

## Requirements
- R1: After reset the serial clock and start outputs are low, no result is flagged valid and cmd_ready is high.
- R2: Op code 1 (single) runs one frame: the start output is high for START_HI (default 4) system cycles with the serial clock low, falls before the first serial clock rise, and exactly 16 serial clock high pulses follow.
- R3: Each serial clock half period lasts max(div_half, MIN_HALF) system cycles, with MIN_HALF defaulting to 16.
- R4: The status bit is the one read at the 2nd rising serial clock edge of a frame and data bits 11 down to 0 are read at edges 3 to 14; res_word holds the data in bits 11:0, the status in bit 12 and zeros in bits 15:13, and res_valid is high for exactly one cycle per frame after the last serial clock fall.
- R5: res_notready is the inverse of the status bit and is meaningful with res_valid.
- R6: Op code 2 (continuous) starts frames one after another until a different command, such as op code 0 (stop), is taken between frames; no frame starts after that.
- R7: Op code 3 (nap) gives two start pulses, each PULSE_HI (default 8) cycles high and PULSE_LO (default 8) cycles low, with the serial clock low and no result.
- R8: Op code 4 (sleep) gives four such start pulses with the serial clock low and no result.
- R9: Op code 5 (wake) drives the serial clock high for WAKE_HI (default 8) cycles with the start output low, then holds cmd_ready low for a further WAKE_SETTLE (default 40) cycles.
- R10: After a sleep, a single conversion repeats frames, each reported, until one reads the status bit high; the wait is then cleared, so a later single conversion with the status low runs only one frame.
- R11: cmd_ready is high only between frames and sequences; op codes 6 and 7 are taken and start no frame, no pulse and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_half | input | DIV_W (8) | Serial clock half period in system cycles, floored at MIN_HALF |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (0 stop, 1 single, 2 continuous, 3 nap, 4 sleep, 5 wake) |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_conv | output | 1 | Conversion start / power-mode strobe |
| adc_dout | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_word | output | WORD_W (16) | Right-justified status and data word |
| res_notready | output | 1 | Result taken while the reference was not ready |

## Verification
The bench stands a behavioural converter model against the controller and goes after the bit alignment, the divider floor, the stop point of continuous runs and the retry after sleep. A design sampling one edge early or late would return the data shifted by a bit with the status in the wrong place, and a missing floor would run the serial clock faster than the converter allows when div_half is small. A stop taken at the wrong moment would leave one extra frame, and a reference wait that never clears, or never arms, would loop forever or hand back a stale not-ready sample as the final result. The power sequences are checked for pulse count and widths, since a wrong count selects the other power mode.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic [2:0] {
      OP_STOP   = 3'd0,
      OP_SINGLE = 3'd1,
      OP_CONT   = 3'd2,
      OP_NAP    = 3'd3,
      OP_SLEEP  = 3'd4,
      OP_WAKE   = 3'd5
   } sadc_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_FRAME,
      ST_DONE,
      ST_PULSE,
      ST_GAP,
      ST_WAKE_HI,
      ST_WAKE_SETTLE
   } sadc_state_e;

   localparam int NAP_PULSES   = 2;
   localparam int SLEEP_PULSES = 4;

endpackage

// File: rtl/sadc_tick_gen.sv
module sadc_tick_gen #(
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_half,
   output logic             tick
);

   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

   generate
      if (MIN_HALF < 2 || MIN_HALF >= (1 << DIV_W)) begin : g_bad_min
         $error("MIN_HALF must be at least 2 and fit in DIV_W bits");
      end
   endgenerate

   logic [DIV_W-1:0] eff_half;
   logic [DIV_W-1:0] cnt;

   always_comb begin
      eff_half = (div_half < MIN_V) ? MIN_V : div_half;
      tick     = run && (cnt == eff_half - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
   parameter int DATA_W    = 12,
   parameter int IDX_W     = 5,
   parameter int STAT_EDGE = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic              din,
   output logic              status,
   output logic [DATA_W-1:0] data
);

   localparam logic [IDX_W-1:0] STAT_I  = IDX_W'(STAT_EDGE);
   localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(STAT_EDGE + 1);
   localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(STAT_EDGE + DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic take_stat;
   logic take_data;
   logic [DATA_W-1:0] data_nx;

   assign take_stat = cap_en && (cap_idx == STAT_I);
   assign take_data = cap_en && (cap_idx >= FIRST_I) && (cap_idx <= LAST_I);

   generate
      if (MSB_FIRST) begin : g_msb
         assign data_nx = {data[DATA_W-2:0], din};
      end else begin : g_lsb
         assign data_nx = {din, data[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
         data   <= '0;
      end else if (clear) begin
         status <= 1'b0;
         data   <= '0;
      end else begin
         if (take_stat) status <= din;
         if (take_data) data   <= data_nx;
      end
   end

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
   import sadc_pkg::*;
#(
   parameter int FRAME_CLKS  = 16,
   parameter int IDX_W       = 5,
   parameter int MIN_HALF    = 16,
   parameter int START_HI    = 4,
   parameter int PULSE_HI    = 8,
   parameter int PULSE_LO    = 8,
   parameter int WAKE_HI     = 8,
   parameter int WAKE_SETTLE = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   output logic             cmd_ready,
   input  logic             tick,
   output logic             run,
   output logic             adc_sclk,
   output logic             adc_conv,
   output logic             cap_en,
   output logic [IDX_W-1:0] cap_idx,
   output logic             cap_clear,
   input  logic             status,
   output logic             res_valid
);

   localparam int M_A      = (START_HI > PULSE_HI) ? START_HI : PULSE_HI;
   localparam int M_B      = (PULSE_LO > WAKE_HI) ? PULSE_LO : WAKE_HI;
   localparam int M_C      = (M_A > M_B) ? M_A : M_B;
   localparam int STEP_MAX = (M_C > WAKE_SETTLE) ? M_C : WAKE_SETTLE;
   localparam int STEP_W   = $clog2(STEP_MAX + 1);
   localparam int CONV_MAX = M_A;

   localparam logic [STEP_W-1:0] START_END  = STEP_W'(START_HI - 1);
   localparam logic [STEP_W-1:0] PHI_END    = STEP_W'(PULSE_HI - 1);
   localparam logic [STEP_W-1:0] PLO_END    = STEP_W'(PULSE_LO - 1);
   localparam logic [STEP_W-1:0] WHI_END    = STEP_W'(WAKE_HI - 1);
   localparam logic [STEP_W-1:0] WSET_END   = STEP_W'(WAKE_SETTLE - 1);
   localparam logic [IDX_W-1:0]  LAST_RISE  = IDX_W'(FRAME_CLKS);

   generate
      if (START_HI < 1 || PULSE_HI < 1 || PULSE_LO < 1 || WAKE_HI < 1 || WAKE_SETTLE < 1) begin : g_bad_t
         $error("all timing counts must be at least 1");
      end
      if ((1 << IDX_W) <= FRAME_CLKS + 1) begin : g_bad_idx
         $error("IDX_W too narrow for FRAME_CLKS");
      end
   endgenerate

   sadc_state_e       state;
   logic [STEP_W-1:0] step;
   logic              sclk_q;
   logic [IDX_W-1:0]  rise_cnt;
   logic              cont;
   logic              ref_wait;
   logic [2:0]        pulses_left;

   always_comb begin
      cmd_ready = (state == ST_IDLE);
      run       = (state == ST_FRAME);
      adc_conv  = (state == ST_START) || (state == ST_PULSE);
      adc_sclk  = ((state == ST_FRAME) && sclk_q) || (state == ST_WAKE_HI);
      cap_en    = (state == ST_FRAME) && tick && !sclk_q;
      cap_idx   = rise_cnt + 1'b1;
      cap_clear = (state == ST_START);
      res_valid = (state == ST_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         step        <= '0;
         sclk_q      <= 1'b0;
         rise_cnt    <= '0;
         cont        <= 1'b0;
         ref_wait    <= 1'b0;
         pulses_left <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               step <= '0;
               if (cmd_valid) begin
                  cont <= 1'b0;
                  case (sadc_op_e'(cmd_op))
                     OP_SINGLE: state <= ST_START;
                     OP_CONT: begin
                        cont  <= 1'b1;
                        state <= ST_START;
                     end
                     OP_NAP: begin
                        pulses_left <= 3'(NAP_PULSES);
                        state       <= ST_PULSE;
                     end
                     OP_SLEEP: begin
                        pulses_left <= 3'(SLEEP_PULSES);
                        ref_wait    <= 1'b1;
                        state       <= ST_PULSE;
                     end
                     OP_WAKE: state <= ST_WAKE_HI;
                     default: state <= ST_IDLE;
                  endcase
               end else if (cont) begin
                  state <= ST_START;
               end
            end
            ST_START: begin
               if (step == START_END) begin
                  step     <= '0;
                  sclk_q   <= 1'b0;
                  rise_cnt <= '0;
                  state    <= ST_FRAME;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_FRAME: begin
               if (tick) begin
                  sclk_q <= ~sclk_q;
                  if (!sclk_q)                       rise_cnt <= rise_cnt + 1'b1;
                  else if (rise_cnt == LAST_RISE)    state    <= ST_DONE;
               end
            end
            ST_DONE: begin
               step <= '0;
               if (status) ref_wait <= 1'b0;
               if (!cont && ref_wait && !status) state <= ST_START;
               else                              state <= ST_IDLE;
            end
            ST_PULSE: begin
               if (step == PHI_END) begin
                  step        <= '0;
                  pulses_left <= pulses_left - 1'b1;
                  state       <= ST_GAP;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_GAP: begin
               if (step == PLO_END) begin
                  step  <= '0;
                  state <= (pulses_left == '0) ? ST_IDLE : ST_PULSE;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_WAKE_HI: begin
               if (step == WHI_END) begin
                  step  <= '0;
                  state <= ST_WAKE_SETTLE;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_WAKE_SETTLE: begin
               if (step == WSET_END) begin
                  step  <= '0;
                  state <= ST_IDLE;
               end else begin
                  step <= step + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Run-length counters of the pin levels, used only by the checks below.
   logic [15:0] sclk_hi_len;
   logic [15:0] conv_hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_hi_len <= '0;
         conv_hi_len <= '0;
      end else begin
         sclk_hi_len <= adc_sclk ? ((sclk_hi_len == 16'hFFFF) ? sclk_hi_len : sclk_hi_len + 1'b1) : '0;
         conv_hi_len <= adc_conv ? ((conv_hi_len == 16'hFFFF) ? conv_hi_len : conv_hi_len + 1'b1) : '0;
      end
   end

   p_frame_half_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_sclk) && $past(run)) |-> (sclk_hi_len >= 16'(MIN_HALF)));

   p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_sclk) && !$past(run)) |-> (sclk_hi_len >= 16'(WAKE_HI)));

   p_conv_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv) |-> (conv_hi_len <= 16'(CONV_MAX)));

   p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && $past(cmd_ready)) |-> (!adc_conv && !adc_sclk));

endmodule

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl #(
   parameter int DIV_W       = 8,
   parameter int DATA_W      = 12,
   parameter int WORD_W      = 16,
   parameter int FRAME_CLKS  = 16,
   parameter int STAT_EDGE   = 2,
   parameter int SYS_NS      = 10,
   parameter int MIN_HALF    = 16,
   parameter int START_HI    = 4,
   parameter int PULSE_HI    = 8,
   parameter int PULSE_LO    = 8,
   parameter int WAKE_HI     = 8,
   parameter int WAKE_SETTLE = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_half,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   output logic              cmd_ready,
   output logic              adc_sclk,
   output logic              adc_conv,
   input  logic              adc_dout,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_word,
   output logic              res_notready
);

   localparam int IDX_W = $clog2(FRAME_CLKS + 2);
   localparam int PAD_W = WORD_W - DATA_W - 1;

   generate
      if (START_HI * SYS_NS >= 120) begin : g_bad_start
         $error("start pulse too long for the early-release window");
      end
      if (WAKE_HI * SYS_NS < 60) begin : g_bad_wake
         $error("wake pulse shorter than 60 ns");
      end
      if (WAKE_SETTLE * SYS_NS < 350) begin : g_bad_settle
         $error("wake settle shorter than 350 ns");
      end
      if (2 * MIN_HALF * SYS_NS < 312) begin : g_bad_rate
         $error("serial clock floor above 3.2 MHz");
      end
      if (FRAME_CLKS < STAT_EDGE + DATA_W) begin : g_bad_frame
         $error("frame too short for status and data");
      end
      if (PAD_W < 0) begin : g_bad_word
         $error("WORD_W too narrow");
      end
   endgenerate

   logic              tick;
   logic              run;
   logic              cap_en;
   logic              cap_clear;
   logic [IDX_W-1:0]  cap_idx;
   logic              status;
   logic [DATA_W-1:0] data;

   sadc_tick_gen #(
      .DIV_W    (DIV_W),
      .MIN_HALF (MIN_HALF)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div_half (div_half),
      .tick     (tick)
   );

   sadc_seq #(
      .FRAME_CLKS  (FRAME_CLKS),
      .IDX_W       (IDX_W),
      .MIN_HALF    (MIN_HALF),
      .START_HI    (START_HI),
      .PULSE_HI    (PULSE_HI),
      .PULSE_LO    (PULSE_LO),
      .WAKE_HI     (WAKE_HI),
      .WAKE_SETTLE (WAKE_SETTLE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_ready (cmd_ready),
      .tick      (tick),
      .run       (run),
      .adc_sclk  (adc_sclk),
      .adc_conv  (adc_conv),
      .cap_en    (cap_en),
      .cap_idx   (cap_idx),
      .cap_clear (cap_clear),
      .status    (status),
      .res_valid (res_valid)
   );

   sadc_capture #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .STAT_EDGE (STAT_EDGE),
      .MSB_FIRST (1'b1)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cap_clear),
      .cap_en  (cap_en),
      .cap_idx (cap_idx),
      .din     (adc_dout),
      .status  (status),
      .data    (data)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign res_word = {{PAD_W{1'b0}}, status, data};
      end else begin : g_nopad
         assign res_word = {status, data};
      end
   endgenerate

   assign res_notready = !status;

endmodule

// File: tb/sadc_host_ctrl_test.sv
module sadc_host_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  div_half = 8'd16;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic        cmd_ready;
   logic        adc_sclk;
   logic        adc_conv;
   logic        adc_dout = 1'b0;
   logic        res_valid;
   logic [15:0] res_word;
   logic        res_notready;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   sadc_host_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .div_half     (div_half),
      .cmd_valid    (cmd_valid),
      .cmd_op       (cmd_op),
      .cmd_ready    (cmd_ready),
      .adc_sclk     (adc_sclk),
      .adc_conv     (adc_conv),
      .adc_dout     (adc_dout),
      .res_valid    (res_valid),
      .res_word     (res_word),
      .res_notready (res_notready)
   );

   // Converter model: status after rise 1, data MSB first after rises 2..13.
   logic [11:0] m_data = 12'h000;
   int          m_frames = 0;
   int          m_rise = 0;
   int          rdy_after = 0;

   always @(posedge adc_conv or posedge adc_sclk) begin
      if (adc_conv) begin
         m_frames = m_frames + 1;
         m_rise   = 0;
      end else begin
         if (m_rise == 0)                      adc_dout <= (m_frames > rdy_after);
         else if (m_rise >= 1 && m_rise <= 12) adc_dout <= m_data[12 - m_rise];
         else                                  adc_dout <= 1'b0;
         m_rise = m_rise + 1;
      end
   end

   // Pin monitor, sampled at the falling clock edge.
   int conv_rises = 0, sclk_rises = 0, res_cnt = 0;
   int conv_len_last = 0, conv_lo_last = 0, sclk_len_last = 0, sclk_lo_last = 0;
   int cur_chi = 0, cur_clo = 0, cur_shi = 0, cur_slo = 0;
   logic [15:0] last_word = '0;
   logic [7:0]  nr_hist = '0;
   logic pc = 1'b0, ps = 1'b0;

   always @(negedge clk) begin
      if (adc_conv) begin
         if (!pc) begin conv_rises = conv_rises + 1; conv_lo_last = cur_clo; end
         cur_chi = cur_chi + 1; cur_clo = 0;
      end else begin
         if (pc) conv_len_last = cur_chi;
         cur_chi = 0; cur_clo = cur_clo + 1;
      end
      if (adc_sclk) begin
         if (!ps) begin sclk_rises = sclk_rises + 1; sclk_lo_last = cur_slo; end
         cur_shi = cur_shi + 1; cur_slo = 0;
      end else begin
         if (ps) sclk_len_last = cur_shi;
         cur_shi = 0; cur_slo = cur_slo + 1;
      end
      if (res_valid) begin
         if (res_cnt < 8) nr_hist[res_cnt] = res_notready;
         res_cnt = res_cnt + 1;
         last_word = res_word;
      end
      pc = adc_conv;
      ps = adc_sclk;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_mon();
      conv_rises = 0; sclk_rises = 0; res_cnt = 0;
      conv_len_last = 0; conv_lo_last = 0; sclk_len_last = 0; sclk_lo_last = 0;
      nr_hist = '0;
   endtask

   task automatic send_cmd(input logic [2:0] op);
      cmd_valid = 1'b1;
      cmd_op    = op;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!cmd_ready) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      check(adc_sclk == 1'b0, "R1 sclk low", adc_sclk, 0);
      check(adc_conv == 1'b0, "R1 conv low", adc_conv, 0);
      check(res_valid == 1'b0, "R1 no result", res_valid, 0);
      check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
   endtask

   task automatic t_single(input logic [11:0] d, input logic [7:0] dv, input int eff);
      @(negedge clk);
      div_half = dv; m_data = d; m_frames = 0; rdy_after = 0;
      clr_mon();
      send_cmd(3'd1);
      wait (res_cnt >= 1);
      wait_idle();
      check(conv_rises == 1, "R2 one start", conv_rises, 1);
      check(conv_len_last == 4, "R2 start width", conv_len_last, 4);
      check(sclk_rises == 16, "R2 clock count", sclk_rises, 16);
      check(sclk_len_last == eff, "R3 high half", sclk_len_last, eff);
      check(sclk_lo_last == eff, "R3 low half", sclk_lo_last, eff);
      check(res_cnt == 1, "R4 one valid", res_cnt, 1);
      check(last_word == {4'b0001, d}, "R4 word", last_word, {4'b0001, d});
      check(nr_hist[0] == 1'b0, "R5 ready flag", nr_hist[0], 0);
   endtask

   task automatic t_notready();
      @(negedge clk);
      div_half = 8'd16; m_data = 12'h3C5; m_frames = 0; rdy_after = 100;
      clr_mon();
      send_cmd(3'd1);
      wait (res_cnt >= 1);
      wait_idle();
      check(last_word == 16'h03C5, "R5 word status clear", last_word, 16'h03C5);
      check(nr_hist[0] == 1'b1, "R5 notready set", nr_hist[0], 1);
      check(res_cnt == 1, "R5 single frame", res_cnt, 1);
   endtask

   task automatic t_cont();
      @(negedge clk);
      div_half = 8'd16; m_data = 12'hA5C; m_frames = 0; rdy_after = 0;
      clr_mon();
      send_cmd(3'd2);
      wait (res_cnt == 3);
      send_cmd(3'd0);
      repeat (1500) @(negedge clk);
      check(res_cnt == 3, "R6 stop between frames", res_cnt, 3);
      check(conv_rises == 3, "R6 starts", conv_rises, 3);
      check(last_word == 16'h1A5C, "R6 word", last_word, 16'h1A5C);
      check(cmd_ready == 1'b1, "R6 idle after stop", cmd_ready, 1);
   endtask

   task automatic t_pulses(input logic [2:0] op, input int n, input string tag);
      @(negedge clk);
      clr_mon();
      send_cmd(op);
      wait_idle();
      check(conv_rises == n, {tag, " pulse count"}, conv_rises, n);
      check(conv_len_last == 8, {tag, " pulse high"}, conv_len_last, 8);
      check(conv_lo_last == 8, {tag, " pulse low"}, conv_lo_last, 8);
      check(sclk_rises == 0, {tag, " clock held low"}, sclk_rises, 0);
      check(res_cnt == 0, {tag, " no result"}, res_cnt, 0);
   endtask

   task automatic t_illegal();
      @(negedge clk);
      clr_mon();
      send_cmd(3'd6);
      send_cmd(3'd7);
      repeat (50) @(negedge clk);
      check(conv_rises == 0, "R11 no start", conv_rises, 0);
      check(sclk_rises == 0, "R11 no clock", sclk_rises, 0);
      check(res_cnt == 0, "R11 no result", res_cnt, 0);
      check(cmd_ready == 1'b1, "R11 ready", cmd_ready, 1);
   endtask

   task automatic t_wake();
      int n;
      @(negedge clk);
      clr_mon();
      send_cmd(3'd5);
      n = 0;
      while (!cmd_ready) begin
         n = n + 1;
         @(negedge clk);
      end
      check(sclk_rises == 1, "R9 one wake pulse", sclk_rises, 1);
      check(sclk_len_last == 8, "R9 wake width", sclk_len_last, 8);
      check(conv_rises == 0, "R9 start low", conv_rises, 0);
      check(n == 48, "R9 busy span", n, 48);
   endtask

   task automatic t_refwait();
      @(negedge clk);
      div_half = 8'd16; m_data = 12'h77E; m_frames = 0; rdy_after = 2;
      clr_mon();
      send_cmd(3'd1);
      wait (res_cnt >= 3);
      wait_idle();
      repeat (200) @(negedge clk);
      check(res_cnt == 3, "R10 retries until ready", res_cnt, 3);
      check(nr_hist[2:0] == 3'b011, "R10 flags per frame", nr_hist[2:0], 3);
      check(last_word == 16'h177E, "R10 final word", last_word, 16'h177E);
      @(negedge clk);
      m_frames = 0; rdy_after = 100;
      clr_mon();
      send_cmd(3'd1);
      wait (res_cnt >= 1);
      wait_idle();
      repeat (800) @(negedge clk);
      check(res_cnt == 1, "R10 wait cleared", res_cnt, 1);
      check(nr_hist[0] == 1'b1, "R10 flagged", nr_hist[0], 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single(12'hA53, 8'd20, 20);
      t_single(12'h001, 8'd3, 16);
      t_single(12'hFFE, 8'd16, 16);
      t_notready();
      t_cont();
      t_pulses(3'd3, 2, "R7 nap");
      t_illegal();
      t_pulses(3'd4, 4, "R8 sleep");
      t_wake();
      t_refwait();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule